// File: doc/BRIEF.md
# Receive Label and Decode Acceptance Filter

This block sits between a serial word receiver and its receive FIFO. Each time the receiver raises its end-of-word strobe with a completed 32-bit word, the filter decides in the same cycle whether the word is kept. Two independent checks exist. The label check compares the word's 8-bit label field against all entries of a small label table. The decode check compares word bits 9 and 10 against two configured values. A word that passes every enabled check is handed to the FIFO write port one clock later. A word that fails any enabled check leaves no trace.

The label table is filled and inspected through a host strobe pair while a table-access mode input is high. Raising that input rewinds internal write and read positions to entry 0. Successive host write strobes then fill consecutive entries, and successive host read strobes return consecutive entries. Received words are discarded for as long as the mode input stays high.

Bit numbering follows the serial word: word bit n (1 to 32) is carried on index n-1 of `rx_word`. So the label is `rx_word[7:0]`, with word bit 1 on index 0, and word bits 9 and 10 are `rx_word[8]` and `rx_word[9]`.

Top module: `lbl_accept_filter`

## Requirements
- R1: With `lbl_chk_en`=1 and the decode check off, a word is forwarded only when `rx_word[7:0]` equals at least one of the 16 table entries. The compare always uses `rx_word[7:0]` in that fixed bit order.
- R2: The label value 0x00 matches like any other value. After reset every table entry holds 0x00.
- R3: With `dec_chk_en`=1 and the label check off, a word is forwarded only when `rx_word[8]`==`dec_bit9` and `rx_word[9]`==`dec_bit10`.
- R4: With both checks enabled, a word is forwarded only if both pass. With neither enabled, every word is forwarded.
- R5: After `tbl_mode` rises, the next 16 `host_wr` strobes write `host_wdata` into entries 0, 1, ..., 15 in that order.
- R6: While `tbl_mode` is high, each `host_rd` strobe makes `host_rvalid` pulse high in the next cycle, with `host_rdata` holding the next entry in order, starting at entry 0.
- R7: Each rise of `tbl_mode` restarts both sequences at entry 0. After 16 writes, further write strobes change nothing. After 16 reads, further read strobes produce no `host_rvalid`.
- R8: While `tbl_mode` is high, received words are never forwarded.
- R9: An accepted word produces a one-cycle `fifo_wr` pulse in the cycle after `rx_eow`, with `fifo_wdata` equal to the word. A rejected word produces no pulse.
- R10: Host strobes while `tbl_mode` is low leave the table unchanged.
- R11: Reset is synchronous and active high. During reset `fifo_wr` and `host_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lbl_chk_en | input | 1 | Enable the label check |
| dec_chk_en | input | 1 | Enable the bits 9/10 check |
| dec_bit9 | input | 1 | Required value of word bit 9 |
| dec_bit10 | input | 1 | Required value of word bit 10 |
| tbl_mode | input | 1 | Table-access mode; its rise rewinds the sequences |
| rx_eow | input | 1 | End-of-word strobe from the receiver |
| rx_word | input | 32 | Received word, bit n on index n-1 |
| host_wr | input | 1 | Host table write strobe |
| host_wdata | input | 8 | Label value to write |
| host_rd | input | 1 | Host table read strobe |
| host_rdata | output | 8 | Label value read back |
| host_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | Word written to the FIFO |

## Verification
The embedded properties guard these relations on every cycle:
- a forward always follows an end-of-word strobe and never follows a cycle in table mode;
- a forward under the decode check carries the configured bits 9 and 10;
- a forward under the label check follows a table hit;
- a read-valid always follows a read strobe in mode;
- the table is stable whenever the mode input was low.

The bench covers what the properties cannot:
- a sweep over every possible label value against a loaded table;
- all combinations of the two enables and the four bits 9/10 patterns;
- the rewinding and saturation of the access sequences;
- the matching of 0x00 straight out of reset.

// File: rtl/lbl_filter_pkg.sv
package lbl_filter_pkg;

    localparam int WORD_W   = 32;
    localparam int LBL_W    = 8;
    localparam int N_LABELS = 16;

    typedef struct packed {
        logic [WORD_W-LBL_W-3:0] upper;
        logic                    bit10;
        logic                    bit9;
        logic [LBL_W-1:0]        label;
    } rx_fields_t;

    typedef struct packed {
        logic lbl_en;
        logic dec_en;
        logic want9;
        logic want10;
    } filt_cfg_t;

    function automatic rx_fields_t split_word(input logic [WORD_W-1:0] w);
        return rx_fields_t'(w);
    endfunction

    function automatic logic decode_pass(input filt_cfg_t c, input rx_fields_t f);
        return !c.dec_en || ((f.bit9 == c.want9) && (f.bit10 == c.want10));
    endfunction

endpackage

// File: rtl/lbl_table.sv
module lbl_table #(
    parameter int N  = 16,
    parameter int LW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode,
    input  logic                 wr_stb,
    input  logic [LW-1:0]        wr_data,
    input  logic                 rd_stb,
    output logic [LW-1:0]        rd_data,
    output logic                 rd_valid,
    output logic [N-1:0][LW-1:0] entries
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = IW + 1;
    localparam logic [CW-1:0] LAST = CW'(N);

    logic          mode_q;
    logic          rise;
    logic [CW-1:0] wcnt, rcnt, wptr, rptr;
    logic          wr_ok, rd_ok;

    assign rise  = mode && !mode_q;
    assign wptr  = rise ? '0 : wcnt;
    assign rptr  = rise ? '0 : rcnt;
    assign wr_ok = mode && wr_stb && (wptr < LAST);
    assign rd_ok = mode && rd_stb && (rptr < LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= 1'b0;
            wcnt     <= '0;
            rcnt     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            entries  <= '0;
        end else begin
            mode_q   <= mode;
            rd_valid <= rd_ok;
            if (wr_ok) begin
                entries[wptr[IW-1:0]] <= wr_data;
                wcnt <= wptr + 1'b1;
            end else if (rise) begin
                wcnt <= '0;
            end
            if (rd_ok) begin
                rd_data <= entries[rptr[IW-1:0]];
                rcnt    <= rptr + 1'b1;
            end else if (rise) begin
                rcnt <= '0;
            end
        end
    end

    // R7: write position never passes the table size
    p_wr_bound_r7: assert property (@(posedge clk) disable iff (rst)
        wcnt <= LAST);
    // R6: read data only follows a read strobe in mode
    p_rvalid_cause_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_stb && mode));
    // R10: table is untouched when mode was low
    p_tbl_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mode)) |-> $stable(entries));
endmodule

// File: rtl/lbl_match.sv
module lbl_match #(
    parameter int N  = 16,
    parameter int LW = 8
) (
    input  logic [N-1:0][LW-1:0] entries,
    input  logic [LW-1:0]        label,
    output logic                 hit
);
    logic [N-1:0] eq;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = (entries[i] == label);
    end

    assign hit = |eq;
endmodule

// File: rtl/lbl_accept_filter.sv
module lbl_accept_filter
    import lbl_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lbl_chk_en,
    input  logic              dec_chk_en,
    input  logic              dec_bit9,
    input  logic              dec_bit10,
    input  logic              tbl_mode,
    input  logic              rx_eow,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              host_wr,
    input  logic [LBL_W-1:0]  host_wdata,
    input  logic              host_rd,
    output logic [LBL_W-1:0]  host_rdata,
    output logic              host_rvalid,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_wdata
);
    logic [N_LABELS-1:0][LBL_W-1:0] entries;
    logic       hit;
    logic       accept;
    rx_fields_t fld;
    filt_cfg_t  cfg;

    assign fld = split_word(rx_word);
    assign cfg = '{lbl_en: lbl_chk_en, dec_en: dec_chk_en,
                   want9: dec_bit9, want10: dec_bit10};

    lbl_table #(.N(N_LABELS), .LW(LBL_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (tbl_mode),
        .wr_stb   (host_wr),
        .wr_data  (host_wdata),
        .rd_stb   (host_rd),
        .rd_data  (host_rdata),
        .rd_valid (host_rvalid),
        .entries  (entries)
    );

    lbl_match #(.N(N_LABELS), .LW(LBL_W)) match_i (
        .entries (entries),
        .label   (fld.label),
        .hit     (hit)
    );

    assign accept = rx_eow && !tbl_mode
                 && (!cfg.lbl_en || hit)
                 && decode_pass(cfg, fld);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            fifo_wr <= accept;
            if (accept) fifo_wdata <= rx_word;
        end
    end

    // R8: nothing is forwarded out of a table-mode cycle
    p_suspend_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !$past(tbl_mode));
    // R9: every forward has an end-of-word cause
    p_cause_r9: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(rx_eow));
    // R3: forwarded word honours the decode setting
    p_decode_r3: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && $past(dec_chk_en)) |->
            (fifo_wdata[8] == $past(dec_bit9) && fifo_wdata[9] == $past(dec_bit10)));
    // R1: forwarded word under label check had a table hit
    p_label_r1: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && $past(lbl_chk_en)) |-> $past(hit));
endmodule

// File: tb/lbl_accept_filter_tb_top.sv
module lbl_accept_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lbl_chk_en = 0, dec_chk_en = 0, dec_bit9 = 0, dec_bit10 = 0;
    logic        tbl_mode = 0, rx_eow = 0, host_wr = 0, host_rd = 0;
    logic [31:0] rx_word = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid, fifo_wr;
    logic [31:0] fifo_wdata;

    int n_chk = 0, n_bad = 0;
    int cycles = 0;
    logic [7:0] model [16];

    always #2.5 clk = ~clk;

    lbl_accept_filter dut_i (
        .clk(clk), .rst(rst), .lbl_chk_en(lbl_chk_en), .dec_chk_en(dec_chk_en),
        .dec_bit9(dec_bit9), .dec_bit10(dec_bit10), .tbl_mode(tbl_mode),
        .rx_eow(rx_eow), .rx_word(rx_word), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            finish_run();
        end
    end

    task automatic enter_mode();
        @(negedge clk); tbl_mode = 1;
        @(negedge clk);
    endtask

    task automatic leave_mode();
        @(negedge clk); tbl_mode = 0;
        @(negedge clk);
    endtask

    task automatic wr_stb(input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic rd_expect(input string req, input logic v, input logic [7:0] d);
        @(negedge clk); host_rd = 1;
        @(negedge clk); host_rd = 0;
        check(req, {31'd0, host_rvalid}, {31'd0, v});
        if (v) check(req, {24'd0, host_rdata}, {24'd0, d});
    endtask

    task automatic load_all(input int seed);
        enter_mode();
        for (int i = 0; i < 16; i++) begin
            model[i] = 8'((i * 37 + seed) & 255);
            wr_stb(model[i]);
        end
        leave_mode();
    endtask

    function automatic logic in_table(input logic [7:0] l);
        for (int i = 0; i < 16; i++) if (model[i] == l) return 1'b1;
        return 1'b0;
    endfunction

    task automatic send(input string req, input logic [31:0] w, input logic exp_fwd);
        @(negedge clk); rx_eow = 1; rx_word = w;
        @(negedge clk); rx_eow = 0;
        check(req, {31'd0, fifo_wr}, {31'd0, exp_fwd});
        if (exp_fwd) check(req, fifo_wdata, w);
    endtask

    function automatic logic [31:0] mk(input int k, input logic b10, input logic b9, input logic [7:0] l);
        return {22'(k * 12345 + 7), b10, b9, l};
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        @(negedge clk);
        check("R11 fifo_wr in reset", {31'd0, fifo_wr}, 32'd0);
        check("R11 rvalid in reset", {31'd0, host_rvalid}, 32'd0);
        repeat (2) @(negedge clk);
        rst = 0;

        // R2: table cleared, 0x00 matches
        lbl_chk_en = 1;
        send("R2 zero label hit", mk(1, 0, 0, 8'h00), 1);
        send("R2 nonzero miss", mk(2, 0, 0, 8'h05), 0);
        enter_mode();
        for (int i = 0; i < 16; i++) rd_expect("R2 reset entry", 1, 8'h00);
        leave_mode();

        // R5, R6: load and read back in order
        load_all(11);
        enter_mode();
        for (int i = 0; i < 16; i++) rd_expect("R6 read order", 1, model[i]);
        rd_expect("R7 read past end", 0, 8'h00);
        // R8: words suspended while in mode
        lbl_chk_en = 0;
        send("R8 suspended", mk(3, 0, 0, model[0]), 0);
        leave_mode();

        // R7: rewind on rise, extra writes ignored
        enter_mode();
        rd_expect("R7 partial", 1, model[0]);
        rd_expect("R7 partial", 1, model[1]);
        leave_mode();
        enter_mode();
        rd_expect("R7 rewind read", 1, model[0]);
        leave_mode();
        enter_mode();
        for (int i = 0; i < 16; i++) wr_stb(model[i]);
        wr_stb(8'hEE);
        leave_mode();
        enter_mode();
        for (int i = 0; i < 16; i++) rd_expect("R7 write saturation", 1, model[i]);
        leave_mode();

        // R10: strobes outside mode ignored
        for (int i = 0; i < 4; i++) begin
            wr_stb(8'hA0 + 8'(i));
            @(negedge clk); host_rd = 1;
            @(negedge clk); host_rd = 0;
            check("R10 no rvalid outside mode", {31'd0, host_rvalid}, 32'd0);
        end
        enter_mode();
        for (int i = 0; i < 16; i++) rd_expect("R10 table unchanged", 1, model[i]);
        leave_mode();

        // R1: every label value against the table
        lbl_chk_en = 1; dec_chk_en = 0;
        for (int l = 0; l < 256; l++)
            send("R1 label sweep", mk(l, l[0], l[1], 8'(l)), in_table(8'(l)));

        // R3, R4, R9: all enable and bits 9/10 combinations
        load_all(200);
        for (int c = 0; c < 16; c++) begin
            lbl_chk_en = c[0]; dec_chk_en = c[1]; dec_bit9 = c[2]; dec_bit10 = c[3];
            for (int p = 0; p < 4; p++) begin
                for (int h = 0; h < 2; h++) begin
                    logic [7:0] lab;
                    logic exp_fwd;
                    lab = h ? model[(c + p) % 16] : 8'(model[0] + 8'd1);
                    if (!h && in_table(lab)) lab = lab + 8'd2;
                    exp_fwd = (!c[0] || in_table(lab))
                           && (!c[1] || (p[0] == c[2] && p[1] == c[3]));
                    send(c[1] ? (c[0] ? "R4 both checks" : "R3 decode check")
                              : (c[0] ? "R1 label check" : "R4 no checks"),
                         mk(c * 8 + p, p[1], p[0], lab), exp_fwd);
                end
            end
        end
        // R9: back-to-back words, single-cycle pulses
        lbl_chk_en = 0; dec_chk_en = 0;
        send("R9 pulse a", mk(90, 1, 1, 8'h3C), 1);
        @(negedge clk);
        check("R9 pulse ends", {31'd0, fifo_wr}, 32'd0);

        finish_run();
    end
endmodule